// File: doc/BRIEF.md
# Scaled-Readout Fixed-Point Multiplier

This block is the multiply stage of a 16-bit fixed-point datapath. It keeps a 16-bit operand register and a 32-bit product register. A 3-bit opcode, sampled on each rising clock edge, chooses what the cycle does. It can load the operand register. It can multiply the operand register by the data input, either as signed or as unsigned numbers. It can multiply the operand register by a short signed constant taken from the low data bits. It can square the data input. It can overwrite the upper half of the product register.

The product register is never read out directly. It always passes through a product scaler, which a 2-bit shift-mode input controls. The scaler's full 32-bit result is an output, and so are its upper and lower 16-bit halves. Because all readout is scaled, saving the product register and restoring it later takes a fixed sequence, described in R7: clear the product, load the saved low half as the operand, multiply it by the constant 1, then write the high half.

Top module: `mpy_unit`

## Requirements
- R1: After an active-low reset, the operand register and the product register are zero. With shift mode 0, every readout port therefore shows zero.
- R2: Opcode 1 (load operand) copies the data input into the operand register at the clock edge. The operand register is visible on `treg_o`. The product register keeps its value.
- R3: Opcode 2 (signed multiply) writes the 32-bit two's-complement product of the operand register and the data input into the product register, at the same clock edge.
- R4: Opcode 3 (unsigned multiply) treats both 16-bit operands as unsigned and writes the full 32-bit unsigned product.
- R5: Opcode 5 (square) feeds the data input to both multiplier inputs. It writes the signed square and leaves the operand register unchanged.
- R6: Opcode 4 (constant multiply) multiplies the operand register by the signed 13-bit constant held in the data input bits 12:0. All numbers are signed. A constant of 0 clears the product register.
- R7: The following sequence rebuilds any earlier product register value P, observed with shift mode 0: constant multiply by 0, load operand with P[15:0], constant multiply by 1, then opcode 7 with P[31:16].
- R8: Opcode 7 (high load) writes the data input into product bits 31:16 and leaves bits 15:0 unchanged.
- R9: Opcode 0 (idle) and opcode 6 (reserved) leave both registers unchanged.
- R10: The scaled readout follows the shift-mode input without a clock. Mode 0 passes the product unchanged. Mode 1 shifts it left by 1 and mode 2 shifts it left by 4, both filling with zeros. Mode 3 shifts it right by 6, copying the sign bit into the vacated positions.
- R11: `prod_hi_o` is bits 31:16 of the scaled value and `prod_lo_o` is bits 15:0. A register write shows on the readouts right after the edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Opcode for this cycle |
| din_i | input | 16 | Data operand, constant field or high-half value |
| pm_i | input | 2 | Product shift mode |
| treg_o | output | 16 | Operand register contents |
| prod_scaled_o | output | 32 | Product register after the scaler |
| prod_hi_o | output | 16 | Upper half of the scaled product |
| prod_lo_o | output | 16 | Lower half of the scaled product |

## Verification
The properties assume that the opcode and data inputs are settled and known at every rising edge once reset is released. They also assume that the shift mode can change in any cycle, because the readout is combinational. The bench drives every input on the falling edge and keeps it steady across the next rising edge, so each opcode is captured exactly once. The random stimulus covers all eight opcode values and all four shift modes. It also mixes in the extreme operands 0x8000, 0x7FFF, 0xFFFF and 0 besides uniform values, so that the sign handling and the unsigned products are tested at their limits.

// File: rtl/mpy_pkg.sv
package mpy_pkg;

   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_LDT  = 3'd1,
      OP_MPY  = 3'd2,
      OP_MPYU = 3'd3,
      OP_MPYK = 3'd4,
      OP_SQR  = 3'd5,
      OP_RSV  = 3'd6,
      OP_LDPH = 3'd7
   } mpy_op_e;

   typedef enum logic [1:0] {
      PM_NONE = 2'd0,
      PM_SHL1 = 2'd1,
      PM_SHL4 = 2'd2,
      PM_SHR6 = 2'd3
   } mpy_pm_e;

   typedef struct packed {
      logic load_t;     // write operand register
      logic load_p;     // write full product register
      logic load_ph;    // write product high half
      logic a_from_din; // multiplier input A taken from data input
      logic b_is_imm;   // multiplier input B is the short constant
      logic is_signed;  // operands sign-extended
   } mpy_ctl_t;

endpackage

// File: rtl/mpy_decode.sv
module mpy_decode
   import mpy_pkg::*;
(
   input  logic [2:0] op,
   output mpy_ctl_t   ctl
);

   always_comb begin
      ctl = '0;
      unique case (op)
         OP_LDT:  ctl.load_t = 1'b1;
         OP_MPY:  begin
            ctl.load_p    = 1'b1;
            ctl.is_signed = 1'b1;
         end
         OP_MPYU: ctl.load_p = 1'b1;
         OP_MPYK: begin
            ctl.load_p    = 1'b1;
            ctl.b_is_imm  = 1'b1;
            ctl.is_signed = 1'b1;
         end
         OP_SQR:  begin
            ctl.load_p     = 1'b1;
            ctl.a_from_din = 1'b1;
            ctl.is_signed  = 1'b1;
         end
         OP_LDPH: ctl.load_ph = 1'b1;
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/mpy_core.sv
module mpy_core #(
   parameter int DW         = 16,
   parameter bit USE_NATIVE = 1'b1
) (
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   input  logic            sgn,
   output logic [2*DW-1:0] prod
);

   localparam int PW = 2 * DW;

   logic [PW-1:0] a_ext;
   logic [PW-1:0] b_ext;

   // Extending to full product width and keeping PW bits of the
   // modular product yields the exact signed or unsigned result.
   assign a_ext = sgn ? {{DW{a[DW-1]}}, a} : {{DW{1'b0}}, a};
   assign b_ext = sgn ? {{DW{b[DW-1]}}, b} : {{DW{1'b0}}, b};

   generate
      if (USE_NATIVE) begin : g_native
         assign prod = a_ext * b_ext;
      end else begin : g_shift_add
         always_comb begin
            prod = '0;
            for (int i = 0; i < PW; i++) begin
               if (b_ext[i]) prod = prod + (a_ext << i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mpy_pscale.sv
module mpy_pscale #(
   parameter int PW    = 32,
   parameter int SHL_A = 1,
   parameter int SHL_B = 4,
   parameter int SHR_C = 6
) (
   input  logic [PW-1:0] p,
   input  logic [1:0]    mode,
   output logic [PW-1:0] q
);

   logic [PW-1:0] shl_a;
   logic [PW-1:0] shl_b;
   logic [PW-1:0] shr_c;

   assign shl_a = p << SHL_A;
   assign shl_b = p << SHL_B;
   assign shr_c = PW'($signed(p) >>> SHR_C);

   always_comb begin
      unique case (mode)
         2'd0:    q = p;
         2'd1:    q = shl_a;
         2'd2:    q = shl_b;
         default: q = shr_c;
      endcase
   end

endmodule

// File: rtl/mpy_unit.sv
module mpy_unit
   import mpy_pkg::*;
#(
   parameter int DW         = 16,
   parameter int IMM_W      = 13,
   parameter bit USE_NATIVE = 1'b1,
   parameter int SHL_A      = 1,
   parameter int SHL_B      = 4,
   parameter int SHR_C      = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      op_i,
   input  logic [15:0]     din_i,
   input  logic [1:0]      pm_i,
   output logic [15:0]     treg_o,
   output logic [31:0]     prod_scaled_o,
   output logic [15:0]     prod_hi_o,
   output logic [15:0]     prod_lo_o
);

   localparam int PW = 2 * DW;
   localparam int HW = PW / 2;

   generate
      if (DW != 16) begin : g_bad_dw
         $error("mpy_unit: port widths assume DW of 16");
      end
      if (IMM_W < 2 || IMM_W >= DW) begin : g_bad_imm
         $error("mpy_unit: IMM_W must lie in 2..DW-1");
      end
      if (SHL_A >= PW || SHL_B >= PW || SHR_C >= PW) begin : g_bad_sh
         $error("mpy_unit: shift amounts must be below product width");
      end
   endgenerate

   mpy_ctl_t      ctl;
   logic [DW-1:0] treg_q;
   logic [PW-1:0] preg_q;
   logic [DW-1:0] imm_ext;
   logic [DW-1:0] mul_a;
   logic [DW-1:0] mul_b;
   logic [PW-1:0] mul_p;
   logic [PW-1:0] scaled;

   mpy_decode u_dec (
      .op  (op_i),
      .ctl (ctl)
   );

   assign imm_ext = {{(DW-IMM_W){din_i[IMM_W-1]}}, din_i[IMM_W-1:0]};
   assign mul_a   = ctl.a_from_din ? din_i   : treg_q;
   assign mul_b   = ctl.b_is_imm   ? imm_ext : din_i;

   mpy_core #(
      .DW         (DW),
      .USE_NATIVE (USE_NATIVE)
   ) u_core (
      .a    (mul_a),
      .b    (mul_b),
      .sgn  (ctl.is_signed),
      .prod (mul_p)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         treg_q <= '0;
      end else if (ctl.load_t) begin
         treg_q <= din_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preg_q <= '0;
      end else if (ctl.load_p) begin
         preg_q <= mul_p;
      end else if (ctl.load_ph) begin
         preg_q[PW-1:HW] <= din_i;
      end
   end

   mpy_pscale #(
      .PW    (PW),
      .SHL_A (SHL_A),
      .SHL_B (SHL_B),
      .SHR_C (SHR_C)
   ) u_scale (
      .p    (preg_q),
      .mode (pm_i),
      .q    (scaled)
   );

   assign treg_o        = treg_q;
   assign prod_scaled_o = scaled;
   assign prod_hi_o     = scaled[PW-1:HW];
   assign prod_lo_o     = scaled[HW-1:0];

endmodule

// File: rtl/mpy_unit_chk.sv
module mpy_unit_chk
   import mpy_pkg::*;
#(
   parameter int DW    = 16,
   parameter int IMM_W = 13
) (
   input logic            clk,
   input logic            rst_n,
   input logic [2:0]      op,
   input logic [DW-1:0]   din,
   input logic [1:0]      pm,
   input logic [DW-1:0]   treg,
   input logic [2*DW-1:0] preg,
   input logic [2*DW-1:0] scaled,
   input logic [DW-1:0]   hi,
   input logic [DW-1:0]   lo
);

   localparam int PW = 2 * DW;

   AST_LDT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_LDT |=> treg == $past(din) && $stable(preg)); // R2

   AST_SIGNED_MUL: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_MPY |=> $signed(preg) == $signed($past(treg)) * $signed($past(din))); // R3

   AST_UNSIGNED_MUL: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_MPYU |=> preg == {{DW{1'b0}}, $past(treg)} * {{DW{1'b0}}, $past(din)}); // R4

   AST_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_SQR |=> $signed(preg) == $signed($past(din)) * $signed($past(din)) && $stable(treg)); // R5

   AST_CONST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_MPYK && din[IMM_W-1:0] == '0 |=> preg == '0); // R6

   AST_HIGH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_LDPH |=> preg[PW-1:DW] == $past(din) && $stable(preg[DW-1:0])); // R8

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NOP || op == OP_RSV) |=> $stable(preg) && $stable(treg)); // R9

   AST_SCALE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      pm == 2'd0 |-> scaled == preg); // R10

   AST_SCALE_SHL4_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      pm == 2'd2 |-> scaled[3:0] == 4'd0 && scaled[PW-1:4] == preg[PW-5:0]); // R10

   AST_SCALE_SHR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      pm == 2'd3 |-> scaled[PW-1:PW-7] == {7{preg[PW-1]}}); // R10

   AST_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
      {hi, lo} == scaled); // R11

endmodule

bind mpy_unit mpy_unit_chk #(
   .DW    (DW),
   .IMM_W (IMM_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .op     (op_i),
   .din    (din_i),
   .pm     (pm_i),
   .treg   (treg_q),
   .preg   (preg_q),
   .scaled (prod_scaled_o),
   .hi     (prod_hi_o),
   .lo     (prod_lo_o)
);

// File: tb/test_mpy_unit.sv
module test_mpy_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic [15:0] din_i = 16'd0;
   logic [1:0]  pm_i = 2'd0;
   logic [15:0] treg_o;
   logic [31:0] prod_scaled_o;
   logic [15:0] prod_hi_o;
   logic [15:0] prod_lo_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // reference state
   logic [15:0] m_t = 16'd0;
   logic [31:0] m_p = 32'd0;

   always #10 clk = ~clk; // 50 MHz

   mpy_unit i_mpy_unit (
      .clk           (clk),
      .rst_n         (rst_n),
      .op_i          (op_i),
      .din_i         (din_i),
      .pm_i          (pm_i),
      .treg_o        (treg_o),
      .prod_scaled_o (prod_scaled_o),
      .prod_hi_o     (prod_hi_o),
      .prod_lo_o     (prod_lo_o)
   );

   function automatic logic [31:0] ref_scale(input logic [31:0] p, input logic [1:0] m);
      case (m)
         2'd0:    return p;
         2'd1:    return p << 1;
         2'd2:    return p << 4;
         default: return 32'($signed(p) >>> 6);
      endcase
   endfunction

   function automatic string op_tag(input logic [2:0] o);
      case (o)
         3'd1:    return "R2";
         3'd2:    return "R3";
         3'd3:    return "R4";
         3'd4:    return "R6";
         3'd5:    return "R5";
         3'd7:    return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic ref_update(input logic [2:0] o, input logic [15:0] d);
      int a;
      int b;
      logic [31:0] ua;
      logic [31:0] ub;
      case (o)
         3'd1: m_t = d;
         3'd2: begin a = $signed(m_t); b = $signed(d); m_p = 32'(a * b); end
         3'd3: begin ua = {16'd0, m_t}; ub = {16'd0, d}; m_p = ua * ub; end
         3'd4: begin a = $signed(m_t); b = $signed(d[12:0]); m_p = 32'(a * b); end
         3'd5: begin a = $signed(d); m_p = 32'(a * a); end
         3'd7: m_p[31:16] = d;
         default: ;
      endcase
   endtask

   task automatic compare(input string tag);
      logic [31:0] exp_s;
      exp_s = ref_scale(m_p, pm_i);
      n_chk++;
      if (treg_o !== m_t || prod_scaled_o !== exp_s ||
          prod_hi_o !== exp_s[31:16] || prod_lo_o !== exp_s[15:0]) begin
         n_fail++;
         $display("FAIL %s (R11 readout): treg=%h scaled=%h hi=%h lo=%h expected treg=%h scaled=%h",
                  tag, treg_o, prod_scaled_o, prod_hi_o, prod_lo_o, m_t, exp_s);
      end
   endtask

   // Drive after a falling edge, reference updated at the rising edge,
   // outputs sampled at the next falling edge.
   task automatic step(input logic [2:0] o, input logic [15:0] d, input logic [1:0] m, input string tag);
      op_i  = o;
      din_i = d;
      pm_i  = m;
      @(posedge clk);
      ref_update(o, d);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: cycles=%0d expected completion", cycles);
         finish_run();
      end
   end

   function automatic logic [15:0] pick_din();
      case ($urandom_range(0, 7))
         0: return 16'h8000;
         1: return 16'h7FFF;
         2: return 16'hFFFF;
         3: return 16'h0000;
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin
      logic [31:0] saved;
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release");

      // directed: signed extremes
      step(3'd1, 16'h8000, 2'd0, "R2");
      step(3'd2, 16'h8000, 2'd0, "R3 min*min");
      step(3'd2, 16'h7FFF, 2'd0, "R3 min*max");
      step(3'd3, 16'hFFFF, 2'd0, "R4 unsigned");
      step(3'd5, 16'hFFFF, 2'd0, "R5 square -1");
      step(3'd5, 16'h8000, 2'd0, "R5 square min");

      // shift modes over one product
      step(3'd7, 16'hC123, 2'd0, "R8 high load");
      step(3'd0, 16'h1234, 2'd1, "R10 mode1");
      step(3'd0, 16'h1234, 2'd2, "R10 mode2");
      step(3'd0, 16'h1234, 2'd3, "R10 mode3 negative");
      step(3'd6, 16'hABCD, 2'd3, "R9 reserved");
      step(3'd4, 16'hE000, 2'd0, "R6 zero constant clears");
      step(3'd1, 16'h0005, 2'd0, "R2");
      step(3'd4, 16'h1FFF, 2'd0, "R6 constant -1");

      // restore sequence
      step(3'd7, 16'h5A5A, 2'd0, "R8");
      step(3'd1, 16'h8001, 2'd0, "R2");
      step(3'd4, 16'h0001, 2'd0, "R6");
      saved = prod_scaled_o;
      step(3'd4, 16'h0000, 2'd2, "R7 clear");
      step(3'd1, saved[15:0], 2'd1, "R7 low to operand");
      step(3'd4, 16'h0001, 2'd3, "R7 times one");
      step(3'd7, saved[31:16], 2'd0, "R7 high load");
      n_chk++;
      if (prod_scaled_o !== saved) begin
         n_fail++;
         $display("FAIL R7 restore: actual=%h expected=%h", prod_scaled_o, saved);
      end

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] o;
         o = 3'($urandom_range(0, 7));
         step(o, pick_din(), 2'($urandom_range(0, 3)), op_tag(o));
      end

      // reset mid-run
      rst_n = 1'b0;
      m_t = '0;
      m_p = '0;
      pm_i = 2'd0;
      #1;
      compare("R1 async reset");
      @(negedge clk);
      rst_n = 1'b1;
      step(3'd0, 16'h0000, 2'd0, "R1 idle after reset");

      finish_run();
   end

endmodule